// File: doc/BRIEF.md
# FIFO Level Watcher with DMA, Interrupt and Wake Flags

This block sits beside a pair of serial-port FIFOs, one for transmit and one for receive, and turns their fill levels and access strobes into service requests. It compares each level with a programmable 5-bit threshold. The transmit side asks for service while it holds fewer entries than its threshold. The receive side asks for service while it holds more entries than its threshold. Each side can raise a DMA request, which is gated by its own enable.

The block keeps sixteen sticky interrupt flags, each with its own enable bit. Writing a 1 to a flag clears it. Flags are raised by threshold conditions, by the empty and full states, by select-line edges, by mode-fault, abort and done events, and by four misuse cases: pushing into a full FIFO or popping from an empty one, each tied to the side (bus or serial) that did it. A second set of four wake flags has its own enables and drives a separate wake line.

A flush strobe for either FIFO clears all pending flags of that FIFO. The FIFO storage listens to the same strobe and resets its pointers.

Top module: `fifo_evt_ctrl`

## Requirements
- R1: The transmit threshold condition holds when tx_level < tx_thresh, where both are unsigned. While the condition holds, irq flag bit 0 and wake flag bit 0 are set. tx_dma_req is 1 on the cycle after a cycle in which the condition held and tx_dma_en = 1. When the level equals the threshold, the request drops.
- R2: The receive threshold condition holds when rx_level > rx_thresh. It sets irq flag bit 2 and wake flag bit 2. rx_dma_req follows the condition one cycle later while rx_dma_en = 1. When the level equals the threshold, no request is made.
- R3: On the cycle after a cycle in which a DMA enable is 0, the DMA request for that direction is 0, even if its threshold condition still holds.
- R4: Flags are sticky. A flag that was set stays set after its cause goes away, until a 1 is written to its bit of irq_clr (or wake_clr). A flag that was cleared stays 0 until its cause returns.
- R5: If a flag's cause is present in the same cycle that its clear bit (or a flush) is 1, the flag stays set.
- R6: Transmit overrun (irq bit 12) is set by bus_tx_push while tx_full = 1. Transmit underrun (irq bit 13) is set by ser_tx_pop while tx_empty = 1. A push while tx_full = 0 sets nothing.
- R7: Receive overrun (irq bit 14) is set by ser_rx_push while rx_full = 1. Receive underrun (irq bit 15) is set by bus_rx_pop while rx_empty = 1. Strobes on the other FIFO's full or empty state have no effect on these bits.
- R8: The state and event inputs set these irq bits: tx_empty sets bit 1, rx_full sets bit 3, sel_assert_evt sets bit 4, sel_release_evt sets bit 5, mode_fault_evt sets bit 8, abort_evt sets bit 9 and done_evt sets bit 11. tx_empty and rx_full also set wake bits 1 and 3.
- R9: irq is 1 exactly when some flag and its bit in irq_en are both 1. A set flag whose enable is 0 leaves irq at 0.
- R10: wake is 1 exactly when some wake flag and its bit in wake_en are both 1.
- R11: A tx_flush pulse clears irq bits 0, 1, 12 and 13 and wake bits 0 and 1, and leaves the receive bits alone. An rx_flush pulse clears irq bits 2, 3, 14 and 15 and wake bits 2 and 3.
- R12: After reset, all flags, both DMA requests, irq and wake are 0.
- R13: irq flag bits 6, 7 and 10 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_level | input | 6 | Transmit FIFO entry count |
| rx_level | input | 6 | Receive FIFO entry count |
| tx_full | input | 1 | Transmit FIFO is full |
| tx_empty | input | 1 | Transmit FIFO is empty |
| rx_full | input | 1 | Receive FIFO is full |
| rx_empty | input | 1 | Receive FIFO is empty |
| bus_tx_push | input | 1 | Bus side writes the transmit FIFO |
| ser_tx_pop | input | 1 | Serial side reads the transmit FIFO |
| ser_rx_push | input | 1 | Serial side writes the receive FIFO |
| bus_rx_pop | input | 1 | Bus side reads the receive FIFO |
| sel_assert_evt | input | 1 | Select line became active |
| sel_release_evt | input | 1 | Select line became inactive |
| mode_fault_evt | input | 1 | Multi-master mode fault |
| abort_evt | input | 1 | Slave abort seen |
| done_evt | input | 1 | Master finished its transactions |
| tx_thresh | input | 5 | Transmit threshold |
| rx_thresh | input | 5 | Receive threshold |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_flush | input | 1 | Flush strobe for the transmit FIFO |
| rx_flush | input | 1 | Flush strobe for the receive FIFO |
| irq_en | input | 16 | Per-flag interrupt enables |
| irq_clr | input | 16 | Write-1-to-clear pulse for the interrupt flags |
| wake_en | input | 4 | Per-flag wake enables |
| wake_clr | input | 4 | Write-1-to-clear pulse for the wake flags |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq_flags | output | 16 | Interrupt flag state |
| wake_flags | output | 4 | Wake flag state |
| irq | output | 1 | Interrupt line |
| wake | output | 1 | Wake line |

## Verification
The threshold compares are driven just below, at and just above the programmed value. This separates a strict compare from an inclusive one and shows which direction each FIFO uses. Each misuse strobe is fired once with its own FIFO's full or empty state low, and once with only the other FIFO's state high. This tells a correct side and FIFO pairing apart from a swapped one. Clear pulses and flush pulses are issued both with and without the flag's cause present. This covers stickiness, precedence of set over clear, and the per-FIFO split of the flush. The enables are toggled against set flags to show the masking on both lines.

// File: rtl/fifo_evt_pkg.sv
// Package: widths and flag bit positions shared by the FIFO event controller.
// Assumes: level counts are wider than thresholds by at least one bit.
package fifo_evt_pkg;
    localparam int LVL_W  = 6;
    localparam int THR_W  = 5;
    localparam int IRQ_W  = 16;
    localparam int WAKE_W = 4;

    // interrupt flag positions
    localparam int B_TX_THR   = 0;
    localparam int B_TX_EMPTY = 1;
    localparam int B_RX_THR   = 2;
    localparam int B_RX_FULL  = 3;
    localparam int B_SEL_ON   = 4;
    localparam int B_SEL_OFF  = 5;
    localparam int B_FAULT    = 8;
    localparam int B_ABORT    = 9;
    localparam int B_DONE     = 11;
    localparam int B_TX_OVR   = 12;
    localparam int B_TX_UNR   = 13;
    localparam int B_RX_OVR   = 14;
    localparam int B_RX_UNR   = 15;

    // wake flag positions
    localparam int W_TX_THR   = 0;
    localparam int W_TX_EMPTY = 1;
    localparam int W_RX_THR   = 2;
    localparam int W_RX_FULL  = 3;

    // groups cleared by a flush of each FIFO
    localparam logic [IRQ_W-1:0]  TX_IRQ_GROUP  = 16'h3003;
    localparam logic [IRQ_W-1:0]  RX_IRQ_GROUP  = 16'hC00C;
    localparam logic [WAKE_W-1:0] TX_WAKE_GROUP = 4'b0011;
    localparam logic [WAKE_W-1:0] RX_WAKE_GROUP = 4'b1100;
    localparam logic [IRQ_W-1:0]  RSVD_GROUP    = 16'h04C0;
endpackage

// File: rtl/thresh_mon.sv
// Module: compares one FIFO level against its threshold and registers a
// DMA request gated by its enable.
// Assumes: LVL_W > THR_W. ABOVE=1 selects "level > threshold", ABOVE=0
// selects "level < threshold".
module thresh_mon #(
    parameter int LVL_W = 6,
    parameter int THR_W = 5,
    parameter bit ABOVE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thresh,
    input  logic             dma_en,
    output logic             cond,
    output logic             dma_req
);
    localparam int PAD = LVL_W - THR_W;

    logic [LVL_W-1:0] thr_ext;
    assign thr_ext = {{PAD{1'b0}}, thresh};

    // compare direction picked by parameter
    generate
        if (ABOVE) begin : g_above
            assign cond = (level > thr_ext);
        end else begin : g_below
            assign cond = (level < thr_ext);
        end
    endgenerate

    // request register: follows the condition, dropped when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) dma_req <= 1'b0;
        else        dma_req <= dma_en & cond;
    end

    a_r3_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !dma_req);
    a_r1_r2_dma_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && cond) |=> dma_req);
endmodule

// File: rtl/w1c_flags.sv
// Module: bank of sticky flags, each set by its cause and cleared by a
// write-1 pulse; a cause in the clear cycle keeps the flag set. Produces
// the OR of flags masked by their enables.
// Assumes: set and clr are single-cycle qualified strobes.
module w1c_flags #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] en,
    output logic [W-1:0] flags,
    output logic         any
);
    // one flop per flag, set has priority over clear
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) flags[i] <= 1'b0;
                else        flags[i] <= set[i] | (flags[i] & ~clr[i]);
            end
        end
    endgenerate

    // masked OR forms the output line
    assign any = |(flags & en);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == '0));
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(set)) == '0));
endmodule

// File: rtl/fifo_evt_ctrl.sv
// Module: top of the FIFO event controller. Builds the interrupt and wake
// set vectors from levels, strobes and events, folds flush into the clear
// vectors and drives the DMA, interrupt and wake lines.
// Assumes: strobes and events are one-cycle pulses in the clk domain.
module fifo_evt_ctrl
    import fifo_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic              bus_tx_push,
    input  logic              ser_tx_pop,
    input  logic              ser_rx_push,
    input  logic              bus_rx_pop,
    input  logic              sel_assert_evt,
    input  logic              sel_release_evt,
    input  logic              mode_fault_evt,
    input  logic              abort_evt,
    input  logic              done_evt,
    input  logic [THR_W-1:0]  tx_thresh,
    input  logic [THR_W-1:0]  rx_thresh,
    input  logic              tx_dma_en,
    input  logic              rx_dma_en,
    input  logic              tx_flush,
    input  logic              rx_flush,
    input  logic [IRQ_W-1:0]  irq_en,
    input  logic [IRQ_W-1:0]  irq_clr,
    input  logic [WAKE_W-1:0] wake_en,
    input  logic [WAKE_W-1:0] wake_clr,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic [IRQ_W-1:0]  irq_flags,
    output logic [WAKE_W-1:0] wake_flags,
    output logic              irq,
    output logic              wake
);
    logic tx_cond, rx_cond;
    logic [IRQ_W-1:0]  irq_set, irq_clr_all;
    logic [WAKE_W-1:0] wake_set, wake_clr_all;

    thresh_mon #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b0)) u_tx_mon (
        .clk(clk), .rst_n(rst_n), .level(tx_level), .thresh(tx_thresh),
        .dma_en(tx_dma_en), .cond(tx_cond), .dma_req(tx_dma_req));

    thresh_mon #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b1)) u_rx_mon (
        .clk(clk), .rst_n(rst_n), .level(rx_level), .thresh(rx_thresh),
        .dma_en(rx_dma_en), .cond(rx_cond), .dma_req(rx_dma_req));

    // interrupt causes mapped to their flag positions
    always_comb begin
        irq_set             = '0;
        irq_set[B_TX_THR]   = tx_cond;
        irq_set[B_TX_EMPTY] = tx_empty;
        irq_set[B_RX_THR]   = rx_cond;
        irq_set[B_RX_FULL]  = rx_full;
        irq_set[B_SEL_ON]   = sel_assert_evt;
        irq_set[B_SEL_OFF]  = sel_release_evt;
        irq_set[B_FAULT]    = mode_fault_evt;
        irq_set[B_ABORT]    = abort_evt;
        irq_set[B_DONE]     = done_evt;
        irq_set[B_TX_OVR]   = bus_tx_push & tx_full;
        irq_set[B_TX_UNR]   = ser_tx_pop & tx_empty;
        irq_set[B_RX_OVR]   = ser_rx_push & rx_full;
        irq_set[B_RX_UNR]   = bus_rx_pop & rx_empty;
    end

    // wake causes mapped to their flag positions
    always_comb begin
        wake_set             = '0;
        wake_set[W_TX_THR]   = tx_cond;
        wake_set[W_TX_EMPTY] = tx_empty;
        wake_set[W_RX_THR]   = rx_cond;
        wake_set[W_RX_FULL]  = rx_full;
    end

    // software clears merged with the per-FIFO flush groups
    always_comb begin
        irq_clr_all  = irq_clr
                     | (tx_flush ? TX_IRQ_GROUP : '0)
                     | (rx_flush ? RX_IRQ_GROUP : '0);
        wake_clr_all = wake_clr
                     | (tx_flush ? TX_WAKE_GROUP : '0)
                     | (rx_flush ? RX_WAKE_GROUP : '0);
    end

    w1c_flags #(.W(IRQ_W)) u_irq_flags (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr_all),
        .en(irq_en), .flags(irq_flags), .any(irq));

    w1c_flags #(.W(WAKE_W)) u_wake_flags (
        .clk(clk), .rst_n(rst_n), .set(wake_set), .clr(wake_clr_all),
        .en(wake_en), .flags(wake_flags), .any(wake));

    a_r13_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags & RSVD_GROUP) == '0);
    a_r6_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tx_push && tx_full) |=> irq_flags[B_TX_OVR]);
    a_r7_rx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rx_pop && rx_empty) |=> irq_flags[B_RX_UNR]);
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
    a_r10_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en == '0) |-> !wake);
    a_r11_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !bus_tx_push && !ser_tx_pop && !tx_empty && !tx_cond)
        |=> ((irq_flags & TX_IRQ_GROUP) == '0));
endmodule

// File: tb/tb_fifo_evt_ctrl.sv
module tb_fifo_evt_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic [5:0]  tx_level, rx_level;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic bus_tx_push, ser_tx_pop, ser_rx_push, bus_rx_pop;
    logic sel_assert_evt, sel_release_evt, mode_fault_evt, abort_evt, done_evt;
    logic [4:0]  tx_thresh, rx_thresh;
    logic tx_dma_en, rx_dma_en, tx_flush, rx_flush;
    logic [15:0] irq_en, irq_clr;
    logic [3:0]  wake_en, wake_clr;
    logic tx_dma_req, rx_dma_req, irq, wake;
    logic [15:0] irq_flags;
    logic [3:0]  wake_flags;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fifo_evt_ctrl dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic neutral();
        tx_level = 6'd10; rx_level = 6'd0; tx_thresh = 5'd0; rx_thresh = 5'd31;
        tx_full = 0; tx_empty = 0; rx_full = 0; rx_empty = 0;
        bus_tx_push = 0; ser_tx_pop = 0; ser_rx_push = 0; bus_rx_pop = 0;
        sel_assert_evt = 0; sel_release_evt = 0; mode_fault_evt = 0;
        abort_evt = 0; done_evt = 0; tx_flush = 0; rx_flush = 0;
        irq_clr = '0; wake_clr = '0;
    endtask

    task automatic clear_all();
        neutral();
        irq_clr = '1; wake_clr = '1;
        tick();
        irq_clr = '0; wake_clr = '0;
    endtask

    task automatic t_reset();
        chk("R12 flags", irq_flags, 0);
        chk("R12 wake flags", wake_flags, 0);
        chk("R12 dma", {tx_dma_req, rx_dma_req}, 0);
        chk("R12 lines", {irq, wake}, 0);
    endtask

    task automatic t_tx_thresh();
        clear_all();
        tx_dma_en = 1; tx_thresh = 5'd4; tx_level = 6'd3;
        tick();
        chk("R1 flag below", irq_flags[0], 1);
        chk("R1 wake below", wake_flags[0], 1);
        chk("R1 dma below", tx_dma_req, 1);
        tx_level = 6'd4;
        tick();
        chk("R1 dma at equal", tx_dma_req, 0);
        chk("R4 sticky tx thr", irq_flags[0], 1);
        irq_clr = 16'h0001;
        tick();
        irq_clr = '0;
        chk("R4 cleared by write 1", irq_flags[0], 0);
        tick();
        chk("R4 stays clear", irq_flags[0], 0);
        tx_level = 6'd3; irq_clr = 16'h0001;
        tick();
        irq_clr = '0;
        chk("R5 set wins over clear", irq_flags[0], 1);
        tx_level = 6'd0;
        tick();
        chk("R3 dma on", tx_dma_req, 1);
        tx_dma_en = 0;
        tick();
        chk("R3 dma dropped", tx_dma_req, 0);
        neutral();
    endtask

    task automatic t_rx_thresh();
        clear_all();
        rx_dma_en = 1; rx_thresh = 5'd5; rx_level = 6'd5;
        tick();
        chk("R2 equal no flag", irq_flags[2], 0);
        chk("R2 equal no dma", rx_dma_req, 0);
        rx_level = 6'd6;
        tick();
        chk("R2 flag above", irq_flags[2], 1);
        chk("R2 wake above", wake_flags[2], 1);
        chk("R2 dma above", rx_dma_req, 1);
        rx_dma_en = 0;
        tick();
        chk("R3 rx dma dropped", rx_dma_req, 0);
        neutral();
    endtask

    task automatic t_misuse();
        clear_all();
        bus_tx_push = 1;
        tick();
        bus_tx_push = 0;
        chk("R6 push not full", irq_flags, 0);
        bus_tx_push = 1; tx_full = 1;
        tick();
        bus_tx_push = 0; tx_full = 0;
        chk("R6 tx overrun", irq_flags, 16'h1000);
        ser_rx_push = 1; tx_full = 1;
        tick();
        ser_rx_push = 0; tx_full = 0;
        chk("R7 rx push other full", irq_flags, 16'h1000);
        clear_all();
        ser_tx_pop = 1; tx_empty = 1;
        tick();
        ser_tx_pop = 0; tx_empty = 0;
        chk("R6 tx underrun", irq_flags, 16'h2002);
        clear_all();
        ser_rx_push = 1; rx_full = 1;
        tick();
        ser_rx_push = 0; rx_full = 0;
        chk("R7 rx overrun", irq_flags, 16'h4008);
        chk("R8 rx full wake", wake_flags, 4'b1000);
        clear_all();
        bus_rx_pop = 1; tx_empty = 1;
        tick();
        bus_rx_pop = 0; tx_empty = 0;
        chk("R7 pop other empty", irq_flags & 16'h8000, 0);
        clear_all();
        bus_rx_pop = 1; rx_empty = 1;
        tick();
        bus_rx_pop = 0; rx_empty = 0;
        chk("R7 rx underrun", irq_flags, 16'h8000);
    endtask

    task automatic t_events();
        clear_all();
        sel_assert_evt = 1;  tick(); sel_assert_evt = 0;
        chk("R8 select on", irq_flags, 16'h0010);
        sel_release_evt = 1; tick(); sel_release_evt = 0;
        mode_fault_evt = 1;  tick(); mode_fault_evt = 0;
        abort_evt = 1;       tick(); abort_evt = 0;
        done_evt = 1;        tick(); done_evt = 0;
        tx_empty = 1;        tick(); tx_empty = 0;
        chk("R8 all events", irq_flags, 16'h0B32);
        chk("R8 tx empty wake", wake_flags, 4'b0010);
        chk("R13 reserved zero", irq_flags & 16'h04C0, 0);
    endtask

    task automatic t_lines();
        clear_all();
        abort_evt = 1; tick(); abort_evt = 0;
        irq_en = 16'hFDFF;
        #1;
        chk("R9 masked flag", irq, 0);
        irq_en = 16'h0200;
        #1;
        chk("R9 enabled flag", irq, 1);
        irq_en = '0;
        rx_full = 1; tick(); rx_full = 0;
        wake_en = 4'b0111;
        #1;
        chk("R10 masked wake", wake, 0);
        wake_en = 4'b1000;
        #1;
        chk("R10 enabled wake", wake, 1);
        wake_en = '0;
    endtask

    task automatic t_flush();
        clear_all();
        tx_thresh = 5'd20; tx_level = 6'd1;
        tick();
        tx_thresh = 5'd0; tx_level = 6'd10;
        bus_tx_push = 1; tx_full = 1; bus_rx_pop = 1; rx_empty = 1;
        tick();
        bus_tx_push = 0; tx_full = 0; bus_rx_pop = 0; rx_empty = 0;
        chk("R11 before flush", irq_flags, 16'h9001);
        tx_flush = 1;
        tick();
        tx_flush = 0;
        chk("R11 tx flush irq", irq_flags, 16'h8000);
        chk("R11 tx flush wake", wake_flags, 0);
        rx_flush = 1;
        tick();
        rx_flush = 0;
        chk("R11 rx flush irq", irq_flags, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        neutral();
        tx_dma_en = 0; rx_dma_en = 0; irq_en = '0; wake_en = '0;
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_tx_thresh();
        t_rx_thresh();
        t_misuse();
        t_events();
        t_lines();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule